// File: doc/BRIEF.md
# Gate Driver Fault Sequencer

This block supervises the protection conditions of a half-bridge gate driver. It takes digitised comparator flags for supply undervoltage and for load short-circuit, an active-low shutdown request, and the sampled level of a shared open-drain fault line. Each internal condition must persist for its own number of clock cycles before it is accepted. An accepted condition emits a fixed-width low pulse on the fault line, stops both gate outputs, and requests a soft turn-off when the low-side switch was conducting.

The fault line works in both directions. Another device on the same line can pull it low, and this block treats that as a fault request. The block ignores the line while it drives the line itself. After every cause has gone away and the fault pulse has finished, the inhibit is lifted. A gate output then turns on again only when its command shows a new rising edge. Holding a command high through a fault does not restart that output.

Top module: `gd_fault_seq`

## Requirements
- R1: During reset and right after it, with `sd_n`=1 and `fo_in`=1, all outputs are 0.
- R2: An undervoltage condition is accepted only once `uv_flag` has been sampled high on UV_FILT consecutive clock edges. A shorter high run has no effect on any output.
- R3: A short-circuit condition is accepted only once `sc_flag` has been sampled high on SC_FILT consecutive clock edges. A shorter run has no effect on any output.
- R4: When a condition is accepted, `fo_oe` (1 = pull the line low) rises on the next clock edge and stays high for exactly FO_WIDTH cycles.
- R5: An acceptance that happens while a pulse is in progress does not lengthen that pulse. It is remembered. After the pulse ends and one cycle passes with `fo_oe` low, a new pulse starts, but only if some condition is still accepted at that point. Otherwise no further pulse follows.
- R6: When `fo_in`=0 while `fo_oe`=0, an external fault request is present. It raises `fault_inhibit` but does not drive `fo_oe`. A low `fo_in` caused by the block's own drive is not counted as an external request.
- R7: While `sd_n`=0, `fault_inhibit` is 1 at once. After `sd_n` has been sampled low on SD_DLY consecutive edges, a fault pulse is issued as in R4.
- R8: `hi_drv`/`lo_drv` follow `hi_cmd`/`lo_cmd`. A drive turns on only on the edge where its command is first sampled high after being low, and only while it is not inhibited. A drive is 0 after any edge at which `fault_inhibit` was 1.
- R9: `soft_off` goes high on an edge where `fault_inhibit` is 1 and `lo_drv` was 1. It then stays high until the edge after `fault_inhibit` returns to 0.
- R10: `fault_inhibit` is 1 exactly when any of these holds: a condition is accepted, an external request is present, `sd_n`=0, or `fo_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uv_flag | input | 1 | Supply undervoltage flag, hysteresis already applied |
| sc_flag | input | 1 | Short-circuit comparator flag |
| sd_n | input | 1 | Shutdown request, active low |
| fo_in | input | 1 | Sampled level of the open-drain fault line |
| hi_cmd | input | 1 | High-side gate command |
| lo_cmd | input | 1 | Low-side gate command |
| fo_oe | output | 1 | Pull the fault line low |
| fault_inhibit | output | 1 | Gate outputs are blocked |
| soft_off | output | 1 | Request a soft turn-off of the low-side switch |
| hi_drv | output | 1 | High-side gate drive |
| lo_drv | output | 1 | Low-side gate drive |

## Verification
The bench builds the block with UV_FILT=6, SC_FILT=3, SD_DLY=2 and FO_WIDTH=5. With these values each filter can be driven one cycle short of its length and one cycle past it. A second acceptance can also land inside a running pulse, in one case with its cause still present when the pulse ends and in another with the cause already gone. These small values also let an external pull overlap the block's own pulse within a few dozen cycles.

// File: rtl/gdf_pkg.sv
package gdf_pkg;

    // Index of each internally filtered fault source
    typedef enum int {
        SRC_UV = 0,
        SRC_SC = 1,
        SRC_SD = 2
    } gdf_src_e;

    localparam int NSRC = 3;

    // Gate command / drive pair
    typedef struct packed {
        logic lo;
        logic hi;
    } gdf_pair_t;

    // Counter width able to hold 0..n
    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/gdf_filter.sv
module gdf_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic flag,
    output logic conf
);
    localparam int W = gdf_pkg::cnt_w(LEN);
    localparam logic [W-1:0] LIM = W'(LEN);

    logic [W-1:0] cnt;

    // Counts consecutive high samples and saturates at LEN
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!flag) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + W'(1);
        end
    end

    assign conf = (cnt == LIM);

    // Acceptance can only stand while the flag was high at the last edge
    p_conf_needs_flag_r2: assert property (@(posedge clk) disable iff (rst)
        conf |-> $past(flag));

endmodule

// File: rtl/gdf_pulse.sv
module gdf_pulse #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic any_conf,
    output logic fo_oe
);
    localparam int PW = gdf_pkg::cnt_w(WIDTH);
    localparam logic [PW-1:0] PLEN = PW'(WIDTH);

    logic [PW-1:0] pcnt;
    logic          pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            pend <= 1'b0;
        end else if (pcnt == '0) begin
            if (rise || (pend && any_conf)) begin
                pcnt <= PLEN;
            end
            pend <= 1'b0;
        end else begin
            pcnt <= pcnt - PW'(1);
            if (rise) begin
                pend <= 1'b1;
            end
        end
    end

    assign fo_oe = (pcnt != '0);

    // Length of the current run of fo_oe, used only for the width check
    logic [PW:0] run_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (fo_oe) begin
            run_len <= run_len + (PW+1)'(1);
        end else begin
            run_len <= '0;
        end
    end

    p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(fo_oe) |-> (run_len == (PW+1)'(WIDTH)));

endmodule

// File: rtl/gdf_gate.sv
module gdf_gate (
    input  logic clk,
    input  logic rst,
    input  logic cmd,
    input  logic block,
    output logic drv
);
    logic cmd_q;

    // Turn-on needs a fresh command edge; any block drops the drive
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= 1'b0;
            drv   <= 1'b0;
        end else begin
            cmd_q <= cmd;
            drv   <= cmd && !block && (drv || !cmd_q);
        end
    end

    p_block_off_r8: assert property (@(posedge clk) disable iff (rst)
        block |=> !drv);

endmodule

// File: rtl/gd_fault_seq.sv
module gd_fault_seq
    import gdf_pkg::*;
#(
    parameter int UV_FILT  = 1600,
    parameter int SC_FILT  = 30,
    parameter int SD_DLY   = 20,
    parameter int FO_WIDTH = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_flag,
    input  logic sc_flag,
    input  logic sd_n,
    input  logic fo_in,
    input  logic hi_cmd,
    input  logic lo_cmd,
    output logic fo_oe,
    output logic fault_inhibit,
    output logic soft_off,
    output logic hi_drv,
    output logic lo_drv
);
    logic [NSRC-1:0] src_flag;
    logic [NSRC-1:0] conf;
    logic [NSRC-1:0] conf_q;
    logic            rise;
    logic            any_conf;
    logic            ext_req;
    logic            blk;

    assign src_flag[SRC_UV] = uv_flag;
    assign src_flag[SRC_SC] = sc_flag;
    assign src_flag[SRC_SD] = ~sd_n;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int LEN = (i == int'(SRC_UV)) ? UV_FILT :
                             (i == int'(SRC_SC)) ? SC_FILT : SD_DLY;
        gdf_filter #(.LEN(LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .flag (src_flag[i]),
            .conf (conf[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) conf_q <= '0;
        else     conf_q <= conf;
    end

    assign rise     = |(conf & ~conf_q);
    assign any_conf = |conf;

    gdf_pulse #(.WIDTH(FO_WIDTH)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .any_conf (any_conf),
        .fo_oe    (fo_oe)
    );

    // A low line counts as external only while this block is not pulling it
    assign ext_req       = ~fo_in & ~fo_oe;
    assign blk           = any_conf | ext_req | ~sd_n | fo_oe;
    assign fault_inhibit = blk;

    gdf_pair_t cmd_p, drv_p;
    assign cmd_p.hi = hi_cmd;
    assign cmd_p.lo = lo_cmd;

    for (genvar s = 0; s < 2; s++) begin : g_side
        gdf_gate u_gate (
            .clk   (clk),
            .rst   (rst),
            .cmd   (cmd_p[s]),
            .block (blk),
            .drv   (drv_p[s])
        );
    end

    assign hi_drv = drv_p.hi;
    assign lo_drv = drv_p.lo;

    always_ff @(posedge clk) begin
        if (rst)      soft_off <= 1'b0;
        else if (blk) soft_off <= soft_off | lo_drv;
        else          soft_off <= 1'b0;
    end

    p_soft_needs_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_off) |-> $past(lo_drv));

    p_soft_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !fault_inhibit |=> !soft_off);

endmodule

// File: tb/gd_fault_seq_tb.sv
module gd_fault_seq_tb;
    localparam int UVF = 6;
    localparam int SCF = 3;
    localparam int SDD = 2;
    localparam int FOW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uv_flag = 1'b0, sc_flag = 1'b0, sd_n = 1'b1;
    logic hi_cmd = 1'b0, lo_cmd = 1'b0, ext_pull = 1'b0;
    logic fo_oe, fault_inhibit, soft_off, hi_drv, lo_drv;
    wire  fo_in = ~(fo_oe | ext_pull);

    int checks = 0;
    int errors = 0;
    string phase = "R1 reset";

    always #5 clk = ~clk;

    gd_fault_seq #(
        .UV_FILT(UVF), .SC_FILT(SCF), .SD_DLY(SDD), .FO_WIDTH(FOW)
    ) u_dut (
        .clk(clk), .rst(rst), .uv_flag(uv_flag), .sc_flag(sc_flag),
        .sd_n(sd_n), .fo_in(fo_in), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .fo_oe(fo_oe), .fault_inhibit(fault_inhibit), .soft_off(soft_off),
        .hi_drv(hi_drv), .lo_drv(lo_drv)
    );

    // Behavioural reference state
    int m_uc = 0, m_sc = 0, m_dc = 0, m_pc = 0;
    bit m_uq = 0, m_sq = 0, m_dq = 0, m_pend = 0;
    bit m_hd = 0, m_ld = 0, m_hq = 0, m_lq = 0, m_soft = 0;

    function automatic bit e_fo();
        return m_pc > 0;
    endfunction

    function automatic bit e_blk();
        return (m_uc >= UVF) || (m_sc >= SCF) || (m_dc >= SDD) ||
               (!fo_in && !e_fo()) || !sd_n || e_fo();
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_uc = 0; m_sc = 0; m_dc = 0; m_pc = 0;
            m_uq = 0; m_sq = 0; m_dq = 0; m_pend = 0;
            m_hd = 0; m_ld = 0; m_hq = 0; m_lq = 0; m_soft = 0;
        end else begin
            bit uc, sc, dc, rise, anyc, blk;
            uc = m_uc >= UVF; sc = m_sc >= SCF; dc = m_dc >= SDD;
            anyc = uc || sc || dc;
            rise = (uc && !m_uq) || (sc && !m_sq) || (dc && !m_dq);
            blk = e_blk();
            m_soft = blk ? (m_soft || m_ld) : 1'b0;
            m_hd = hi_cmd && !blk && (m_hd || !m_hq);
            m_ld = lo_cmd && !blk && (m_ld || !m_lq);
            m_hq = hi_cmd; m_lq = lo_cmd;
            if (m_pc == 0) begin
                if (rise || (m_pend && anyc)) m_pc = FOW;
                m_pend = 0;
            end else begin
                m_pc = m_pc - 1;
                if (rise) m_pend = 1;
            end
            m_uq = uc; m_sq = sc; m_dq = dc;
            m_uc = uv_flag ? ((m_uc < UVF) ? m_uc + 1 : m_uc) : 0;
            m_sc = sc_flag ? ((m_sc < SCF) ? m_sc + 1 : m_sc) : 0;
            m_dc = !sd_n   ? ((m_dc < SDD) ? m_dc + 1 : m_dc) : 0;
        end
    end

    task automatic chk(input logic act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", phase, what, act, exp, $time);
        end
    endtask

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        chk(fo_oe,         e_fo(),  "R4 fo_oe");
        chk(fault_inhibit, e_blk(), "R10 fault_inhibit");
        chk(soft_off,      m_soft,  "R9 soft_off");
        chk(hi_drv,        m_hd,    "R8 hi_drv");
        chk(lo_drv,        m_ld,    "R8 lo_drv");
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired: got hang expected completion");
        finish_run();
    end

    initial begin
        step(3);
        #3;
        chk(fo_oe | fault_inhibit | soft_off | hi_drv | lo_drv, 1'b0, "R1 outputs in reset");
        step(1);
        rst = 1'b0;
        step(2);

        phase = "R8 command edges";
        hi_cmd = 1; step(3);
        hi_cmd = 0; lo_cmd = 1; step(3);

        phase = "R2 undervoltage filter";
        uv_flag = 1; step(UVF - 1);
        uv_flag = 0; step(3);
        uv_flag = 1; step(15);
        uv_flag = 0; step(12);

        phase = "R8 fresh edge after fault";
        step(2);
        lo_cmd = 0; step(2);
        lo_cmd = 1; step(3);

        phase = "R3 short-circuit filter";
        sc_flag = 1; step(SCF - 1);
        sc_flag = 0; step(2);
        sc_flag = 1; step(SCF + 1);
        sc_flag = 0; step(10);

        phase = "R5 retrigger held";
        lo_cmd = 0; step(1); lo_cmd = 1; step(2);
        uv_flag = 1; step(UVF + 1);
        sc_flag = 1; step(SCF + 2);
        uv_flag = 0; step(10);
        sc_flag = 0; step(12);

        phase = "R5 retrigger dropped";
        uv_flag = 1; step(UVF + 1);
        sc_flag = 1; step(SCF);
        sc_flag = 0; uv_flag = 0; step(14);

        phase = "R6 external request";
        lo_cmd = 0; step(1); lo_cmd = 1; step(2);
        ext_pull = 1; step(2);
        #3;
        chk(fo_oe, 1'b0, "R6 no own drive on external pull");
        chk(fault_inhibit, 1'b1, "R6 inhibit on external pull");
        step(3);
        ext_pull = 0; step(4);
        sc_flag = 1; step(SCF + 1);
        ext_pull = 1; step(6);
        sc_flag = 0; step(4);
        ext_pull = 0; step(6);

        phase = "R7 shutdown";
        hi_cmd = 1; lo_cmd = 0; step(3);
        sd_n = 0; step(1);
        sd_n = 1; step(4);
        hi_cmd = 0; step(1); hi_cmd = 1; step(2);
        sd_n = 0; step(10);
        sd_n = 1; step(10);

        phase = "R10 idle release";
        hi_cmd = 0; step(5);
        #3;
        chk(fault_inhibit, 1'b0, "R10 released when idle");
        finish_run();
    end
endmodule